// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address stream for read and write bursts on a two-bank synchronous graphics DRAM. The column address is eight bits wide by default. A start strobe captures a start column and a four-bit mode value. The block then issues one column address per clock, with a valid flag and a last-beat flag, until the burst is complete.

The low three mode bits set the burst length. Bit 3 selects linear (wrapping count) or interleaved (XOR) ordering. Column bits above the burst window keep the start value for the whole burst. A full-page burst walks all 2^COL_W columns and is the only kind that a stop request can cut short. A fresh start strobe always takes over from a burst in progress. A mode value with no legal meaning gives a single beat and raises an error flag beside it.

Top module: `burst_col_gen`

## Requirements
- R1: Mode bits [2:0] set the number of beats: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives 2^COL_W (a full page).
- R2: Mode bit [3] picks the ordering: 0 is linear and 1 is interleaved.
- R3: In linear order, beat k carries the low window bits (start + k) modulo the burst length, so the count wraps inside the aligned window. For example, length 4 starting at offset 2 gives offsets 2, 3, 0, 1.
- R4: In interleaved order, beat k carries the low window bits (start offset XOR k). For example, length 8 starting at offset 5 gives offsets 5, 4, 7, 6, 1, 0, 3, 2.
- R5: The column bits above the burst window equal those of the start column on every beat.
- R6: Codes 100, 101 and 110, and code 111 with bit [3] set, are errors. Such a burst is one beat at the start column, with mode_err_o high on that beat; mode_err_o is low on every other beat.
- R7: When start_i is sampled high at an edge, beat 0 is valid from that edge on. Further beats follow on consecutive clocks with no gap.
- R8: col_last_o is high only on the final beat of a burst that runs its full length. col_valid_o is low on the clock after that beat unless a new start arrives.
- R9: During a full-page burst, stop_i sampled high at an edge makes the beat shown at that edge the final one. col_valid_o is low from that edge on.
- R10: stop_i has no effect on a burst of length 1, 2, 4 or 8. Every beat is still issued.
- R11: start_i sampled high during a burst ends that burst. Beat 0 of the new burst is shown from the same edge.
- R12: While reset is held, col_valid_o, col_last_o and mode_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a burst with start_col_i and mode_i |
| start_col_i | input | COL_W | Start column |
| mode_i | input | 4 | [2:0] length code, [3] ordering |
| stop_i | input | 1 | End a full-page burst after the current beat |
| col_o | output | COL_W | Column address of the current beat |
| col_valid_o | output | 1 | col_o carries a beat |
| col_last_o | output | 1 | Final beat of a completed burst |
| mode_err_o | output | 1 | Current beat comes from an illegal mode code |

## Verification
Linear and interleaved bursts are run from start offsets that are not zero. This separates wrap-in-window from plain incrementing, and XOR ordering from add ordering. The start columns have set bits above the window, which exposes any change to the upper bits. A full-page burst that starts near the top of the column range shows the modulo wrap. Stop requests during fixed-length and full-page bursts, a start during a burst, back-to-back bursts and each illegal code separate ignored from honoured inputs.

// File: rtl/burst_col_pkg.sv
// Shared constants for the burst column generator.
// Assumes a 4-bit mode value: [2:0] length code, [3] ordering.
package burst_col_pkg;
    localparam logic [2:0] LEN_CODE_1    = 3'b000;
    localparam logic [2:0] LEN_CODE_2    = 3'b001;
    localparam logic [2:0] LEN_CODE_4    = 3'b010;
    localparam logic [2:0] LEN_CODE_8    = 3'b011;
    localparam logic [2:0] LEN_CODE_PAGE = 3'b111;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_mode_decode.sv
// Decodes the mode value into a window mask and flags.
// mask has ones on the column bits that vary during the burst.
// Illegal codes give mask 0 (one beat) and raise err_o.
// Assumes COL_W >= 3.
module burst_mode_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [3:0]       mode_i,
    output logic [COL_W-1:0] mask_o,
    output burst_order_e     order_o,
    output logic             full_o,
    output logic             err_o
);
    // Map the length code and ordering bit to a mask and flags.
    always_comb begin
        mask_o  = '0;
        full_o  = 1'b0;
        err_o   = 1'b0;
        order_o = burst_order_e'(mode_i[3]);
        case (mode_i[2:0])
            LEN_CODE_1: mask_o = '0;
            LEN_CODE_2: mask_o = COL_W'(1);
            LEN_CODE_4: mask_o = COL_W'(3);
            LEN_CODE_8: mask_o = COL_W'(7);
            LEN_CODE_PAGE: begin
                if (order_o == ORD_XOR) begin
                    err_o = 1'b1;
                end else begin
                    mask_o = '1;
                    full_o = 1'b1;
                end
            end
            default: err_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
// Beat counter and burst activity tracking.
// A start clears the beat index and makes the block active.
// The burst ends after the beat whose index equals the window mask,
// or after any beat of a full-page burst when stop is sampled high.
// Assumes mask_i and full_i are the settings captured for the current burst.
module burst_beat_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic             last_o
);
    logic             active_q;
    logic [COL_W-1:0] beat_q;

    // The final beat is reached when the index fills the window.
    assign last_o   = active_q && (beat_q == mask_i);
    assign active_o = active_q;
    assign beat_o   = beat_q;

    // Advance, restart or end the burst on each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            beat_q   <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
        end else if (active_q) begin
            if (last_o || (full_i && stop_i)) begin
                active_q <= 1'b0;
            end else begin
                beat_q <= beat_q + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/burst_addr_calc.sv
// Forms the column address of a beat from the start column.
// Bits inside the window take the ordered offset; bits outside keep the start value.
// Assumes beat_i never exceeds mask_i.
module burst_addr_calc
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  burst_order_e     order_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] offset;

    // Pick the linear sum or the XOR offset.
    always_comb begin
        if (order_i == ORD_XOR) begin
            offset = base_i ^ beat_i;
        end else begin
            offset = base_i + beat_i;
        end
    end

    // Merge each bit from the window offset or the start column.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col_o[i] = mask_i[i] ? offset[i] : base_i[i];
    end
endmodule

// File: rtl/burst_col_gen.sv
// Top of the burst column generator.
// Captures the start column and decoded mode on a start strobe, then
// shows one column per clock with valid, last and error flags.
// Assumes mode_i and start_col_i are only meaningful with start_i.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [3:0]       mode_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_valid_o,
    output logic             col_last_o,
    output logic             mode_err_o
);
    logic [COL_W-1:0] dec_mask;
    burst_order_e     dec_order;
    logic             dec_full;
    logic             dec_err;

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    burst_order_e     order_q;
    logic             full_q;
    logic             err_q;

    logic             active;
    logic [COL_W-1:0] beat;
    logic             last;

    burst_mode_decode #(.COL_W(COL_W)) i_decode (
        .mode_i  (mode_i),
        .mask_o  (dec_mask),
        .order_o (dec_order),
        .full_o  (dec_full),
        .err_o   (dec_err)
    );

    // Hold the burst settings from the start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            mask_q  <= '0;
            order_q <= ORD_LINEAR;
            full_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (start_i) begin
            base_q  <= start_col_i;
            mask_q  <= dec_mask;
            order_q <= dec_order;
            full_q  <= dec_full;
            err_q   <= dec_err;
        end
    end

    burst_beat_ctrl #(.COL_W(COL_W)) i_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .mask_i   (mask_q),
        .full_i   (full_q),
        .active_o (active),
        .beat_o   (beat),
        .last_o   (last)
    );

    burst_addr_calc #(.COL_W(COL_W)) i_addr (
        .base_i  (base_q),
        .beat_i  (beat),
        .mask_i  (mask_q),
        .order_i (order_q),
        .col_o   (col_o)
    );

    assign col_valid_o = active;
    assign col_last_o  = last;
    assign mode_err_o  = active && err_q;
endmodule

// File: rtl/burst_col_gen_checker.sv
// Protocol checks for the burst column generator, bound to its top.
module burst_col_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic stop_i,
    input logic col_valid_o,
    input logic col_last_o,
    input logic mode_err_o,
    input logic full_q
);
    a_r7_start_gives_beat: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> col_valid_o);

    a_r8_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        col_last_o |-> col_valid_o);

    a_r8_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last_o && !start_i) |=> !col_valid_o);

    a_r9_stop_ends_page: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && full_q && stop_i && !start_i) |=> !col_valid_o);

    a_r10_fixed_keeps_going: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && !full_q && !col_last_o) |=> col_valid_o);

    a_r6_error_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> col_last_o);
endmodule

bind burst_col_gen burst_col_gen_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .col_valid_o (col_valid_o),
    .col_last_o  (col_last_o),
    .mode_err_o  (mode_err_o),
    .full_q      (full_q)
);

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;
    localparam int COL_W = 8;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [3:0]       mode_i = '0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             col_valid_o;
    logic             col_last_o;
    logic             mode_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [COL_W:0] exp_q[$];
    string          tag_q[$];

    always #10 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) i_burst_col_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .mode_i      (mode_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .col_valid_o (col_valid_o),
        .col_last_o  (col_last_o),
        .mode_err_o  (mode_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Beats from the mode code, per R1 and R6 (illegal codes give one beat).
    function automatic int len_of(input logic [3:0] m);
        case (m[2:0])
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return m[3] ? 1 : PAGE;
            default: return 1;
        endcase
    endfunction

    function automatic bit err_of(input logic [3:0] m);
        return (m[2:0] inside {3'b100, 3'b101, 3'b110}) || (m == 4'b1111);
    endfunction

    // Monitor: compare each valid beat with the next scoreboard item.
    always @(negedge clk) begin
        if (rst_n && col_valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8/R9 unexpected beat", int'(col_o), 0);
            end else begin
                logic [COL_W:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({col_last_o, col_o} == e, t, int'({col_last_o, col_o}), int'(e));
            end
        end
    end

    // Driver: start a burst, hold for `hold` cycles, optionally stop at beat stop_at.
    task automatic burst(input logic [3:0] m, input logic [COL_W-1:0] c,
                         input int hold, input int stop_at, input string tag);
        int len;
        int n;
        int so;
        int off;
        len = len_of(m);
        so  = int'(c) % len;
        n   = (hold < len) ? hold : len;
        if (m[2:0] == 3'b111 && !m[3] && stop_at >= 0 && stop_at + 1 < n) n = stop_at + 1;
        for (int k = 0; k < n; k++) begin
            off = m[3] ? (so ^ k) : ((so + k) % len);
            exp_q.push_back({(k == len - 1), COL_W'(int'(c) - so + off)});
            tag_q.push_back(tag);
        end
        start_i     = 1'b1;
        start_col_i = c;
        mode_i      = m;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            stop_i  = (i == stop_at);
            if (i == 0) check(mode_err_o == err_of(m), "R6 error flag", int'(mode_err_o), int'(err_of(m)));
        end
        stop_i = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
        check(col_valid_o == 1'b0, "R8 idle after burst", int'(col_valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({col_valid_o, col_last_o, mode_err_o} == 3'b000, "R12 reset outputs",
              int'({col_valid_o, col_last_o, mode_err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        burst(4'b0010, 8'h4A, 4, -1, "R3 R5 linear len4");
        gap(2);
        burst(4'b1011, 8'h35, 8, -1, "R4 R2 xor len8");
        gap(2);
        burst(4'b0000, 8'h9C, 1, -1, "R1 len1");
        gap(2);
        burst(4'b1001, 8'h11, 2, -1, "R1 R4 xor len2");
        gap(2);
        burst(4'b0011, 8'hDE, 8, -1, "R3 R5 linear len8");
        gap(2);
        burst(4'b0111, 8'hF0, PAGE, -1, "R1 R3 full page wrap");
        gap(2);
        burst(4'b0111, 8'h05, 20, 10, "R9 stop full page");
        gap(1);
        burst(4'b0011, 8'h63, 8, 3, "R10 stop ignored len8");
        gap(2);
        burst(4'b1010, 8'h77, 4, 0, "R10 stop ignored xor len4");
        gap(2);
        burst(4'b0101, 8'h3B, 3, -1, "R6 reserved code");
        gap(1);
        burst(4'b1111, 8'hC4, 3, -1, "R6 page with xor");
        gap(1);
        burst(4'b0011, 8'h20, 3, -1, "R11 interrupted");
        burst(4'b0010, 8'h7E, 4, -1, "R11 R7 takeover");
        burst(4'b0001, 8'h81, 2, -1, "R7 back to back a");
        burst(4'b0001, 8'h82, 2, -1, "R7 back to back b");
        gap(3);
        check(exp_q.size() == 0, "R7 all beats seen", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule